// File: doc/BRIEF.md
# Charge Status LED Pattern Generator

This block turns a per-cell charge status into the drive for an open-drain status indicator. Each indicator output is a pull-down enable: a 1 pulls the pin low and lights the LED, and a 0 releases the pin to high impedance. What the pin does for a given status depends on a shared display-mode code. Each mode maps the four status values to a steady level or to a blink pattern built from whole 0.16 s slots.

Timing comes from a one-cycle `slotTick` pulse issued once per 0.16 s. Each indicator channel keeps a six-slot phase counter. Every pattern is read from that counter: five slots low then one released, three low then three released, or alternating single slots. A change of the channel's status or of the display mode sends the phase back to the first low slot, so no fragment of an old pattern is left behind. When several cells are charged in series, only the first indicator reports, and the others stay released.

Top module: `led_status_pattern`

## Requirements
- R1: Status code 0 (no battery) keeps the output released (0) in every display mode.
- R2: In mode code 0 (select pin low), status code 1 (charging) drives the output low (1) steadily.
- R3: In mode code 0, status code 2 (maintenance) repeats five slots low and then one slot released.
- R4: In mode code 0, status code 3 (fault) repeats three slots low and then three slots released.
- R5: In mode code 1 (select pin open), charging is steady low, maintenance is released, and fault alternates one slot low and one slot released.
- R6: In mode code 2 (select pin high), charging repeats five slots low and one released, maintenance is steady low, and fault alternates one slot low and one slot released.
- R7: Mode code 3 behaves exactly like mode code 1.
- R8: A change of a channel's status code, or of the mode code, restarts that channel's pattern at its first low slot on the next clock edge. This holds even when a slot tick arrives in the same cycle.
- R9: Between slot ticks, with status and mode unchanged, the output does not change.
- R10: When `seriesMode` is 1, every output except channel 0 is released and channel 0 follows its own status. When `seriesMode` is 0, each channel follows its own status.
- R11: While reset is asserted, every output is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotTick | input | 1 | One-cycle pulse marking each 0.16 s slot |
| seriesMode | input | 1 | 1: only channel 0 reports; 0: one indicator per cell |
| dispMode | input | 2 | Display mode: 0 low, 1 open, 2 high, 3 treated as open |
| cellStatus | input | 2*NUM_LEDS | Per-channel status, channel i in bits [2i+1:2i]: 0 empty, 1 charging, 2 maintenance, 3 fault |
| ledPullLow | output | NUM_LEDS | Per-channel pull-down enable; 1 = pin low, 0 = released |

## Verification
A restart caused by a status or mode change can land in the same cycle as a slot tick. In that cycle the restart must win, or every following slot of the pattern is shifted by one. The bench provokes this by raising the tick in the cycle where it applies a new status. It then walks twelve slots and compares each one against the expected slot sequence starting at phase zero. A five-low/one-released pattern shows any off-by-one offset within the first frame.

// File: rtl/ledpat_pkg.sv
package ledpat_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY    = 2'd0,
    ST_CHARGING = 2'd1,
    ST_MAINT    = 2'd2,
    ST_FAULT    = 2'd3
  } cellStat_e;

  typedef enum logic [1:0] {
    DISP_LOW  = 2'd0,
    DISP_OPEN = 2'd1,
    DISP_HIGH = 2'd2,
    DISP_ALT  = 2'd3
  } dispSel_e;

  typedef enum logic [2:0] {
    PAT_OFF,
    PAT_ON,
    PAT_LONG,
    PAT_HALF,
    PAT_FAST
  } patKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic advance;
  } phaseStrobe_t;

  function automatic patKind_e selectPattern(cellStat_e st, dispSel_e dm);
    patKind_e pk;
    pk = PAT_OFF;
    unique case (dm)
      DISP_LOW: begin
        unique case (st)
          ST_EMPTY:    pk = PAT_OFF;
          ST_CHARGING: pk = PAT_ON;
          ST_MAINT:    pk = PAT_LONG;
          ST_FAULT:    pk = PAT_HALF;
        endcase
      end
      DISP_HIGH: begin
        unique case (st)
          ST_EMPTY:    pk = PAT_OFF;
          ST_CHARGING: pk = PAT_LONG;
          ST_MAINT:    pk = PAT_ON;
          ST_FAULT:    pk = PAT_FAST;
        endcase
      end
      DISP_OPEN, DISP_ALT: begin
        unique case (st)
          ST_EMPTY:    pk = PAT_OFF;
          ST_CHARGING: pk = PAT_ON;
          ST_MAINT:    pk = PAT_OFF;
          ST_FAULT:    pk = PAT_FAST;
        endcase
      end
    endcase
    return pk;
  endfunction

endpackage

// File: rtl/ledpat_ctrl.sv
module ledpat_ctrl
  import ledpat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         slotTick,
  input  cellStat_e    status,
  input  dispSel_e     mode,
  output phaseStrobe_t strobe
);

  cellStat_e statusQ;
  dispSel_e  modeQ;
  logic      changed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= ST_EMPTY;
      modeQ   <= DISP_LOW;
    end else begin
      statusQ <= status;
      modeQ   <= mode;
    end
  end

  assign changed = (status != statusQ) || (mode != modeQ);

  // restart dominates a coincident tick
  always_comb begin
    strobe.restart = changed;
    strobe.advance = slotTick && !changed;
  end

endmodule

// File: rtl/ledpat_datapath.sv
module ledpat_datapath
  import ledpat_pkg::*;
#(
  parameter int FRAME_SLOTS    = 6,
  parameter int LONG_LOW_SLOTS = 5,
  parameter int HALF_LOW_SLOTS = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  cellStat_e    status,
  input  dispSel_e     mode,
  input  phaseStrobe_t strobe,
  output logic         pullLow
);

  localparam int PW = (FRAME_SLOTS > 1) ? $clog2(FRAME_SLOTS) : 1;
  localparam logic [PW-1:0] LAST_PHASE = PW'(FRAME_SLOTS - 1);
  localparam logic [PW-1:0] LONG_END   = PW'(LONG_LOW_SLOTS);
  localparam logic [PW-1:0] HALF_END   = PW'(HALF_LOW_SLOTS);

  logic [PW-1:0] phase, phaseNext;
  patKind_e      kind;
  logic          lowNext;

  always_comb begin
    phaseNext = phase;
    if (strobe.restart)
      phaseNext = '0;
    else if (strobe.advance)
      phaseNext = (phase == LAST_PHASE) ? '0 : phase + 1'b1;
  end

  assign kind = selectPattern(status, mode);

  always_comb begin
    unique case (kind)
      PAT_OFF:  lowNext = 1'b0;
      PAT_ON:   lowNext = 1'b1;
      PAT_LONG: lowNext = (phaseNext < LONG_END);
      PAT_HALF: lowNext = (phaseNext < HALF_END);
      PAT_FAST: lowNext = !phaseNext[0];
      default:  lowNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      pullLow <= 1'b0;
    end else begin
      phase   <= phaseNext;
      pullLow <= lowNext;
    end
  end

endmodule

// File: rtl/led_status_pattern.sv
module led_status_pattern
  import ledpat_pkg::*;
#(
  parameter int NUM_LEDS       = 2,
  parameter int FRAME_SLOTS    = 6,
  parameter int LONG_LOW_SLOTS = 5,
  parameter int HALF_LOW_SLOTS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  slotTick,
  input  logic                  seriesMode,
  input  logic [1:0]            dispMode,
  input  logic [2*NUM_LEDS-1:0] cellStatus,
  output logic [NUM_LEDS-1:0]   ledPullLow
);

  logic [NUM_LEDS-1:0] chLow;

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_ch
    phaseStrobe_t strobe;
    cellStat_e    st;
    dispSel_e     dm;

    assign st = cellStat_e'(cellStatus[2*i +: 2]);
    assign dm = dispSel_e'(dispMode);

    ledpat_ctrl u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .slotTick(slotTick),
      .status  (st),
      .mode    (dm),
      .strobe  (strobe)
    );

    ledpat_datapath #(
      .FRAME_SLOTS   (FRAME_SLOTS),
      .LONG_LOW_SLOTS(LONG_LOW_SLOTS),
      .HALF_LOW_SLOTS(HALF_LOW_SLOTS)
    ) u_dp (
      .clk    (clk),
      .rstN   (rstN),
      .status (st),
      .mode   (dm),
      .strobe (strobe),
      .pullLow(chLow[i])
    );

    if (i == 0) begin : g_lead
      assign ledPullLow[i] = chLow[i];
    end else begin : g_follow
      assign ledPullLow[i] = chLow[i] && !seriesMode;
    end
  end

endmodule

// File: rtl/ledpat_checker.sv
module ledpat_checker #(
  parameter int NUM_LEDS = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  slotTick,
  input logic                  seriesMode,
  input logic [1:0]            dispMode,
  input logic [2*NUM_LEDS-1:0] cellStatus,
  input logic [NUM_LEDS-1:0]   ledPullLow
);

  // R1: empty cell leaves channel 0 released on the next edge
  p_empty_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cellStatus[1:0] == 2'd0) |=> !ledPullLow[0]);

  // R2: mode 0 charging is steady low
  p_dm0_charging_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dispMode == 2'd0 && cellStatus[1:0] == 2'd1) |=> ledPullLow[0]);

  // R8: entering fault starts on a low slot in every mode
  p_fault_restart_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cellStatus[1:0] == 2'd3 && $past(cellStatus[1:0]) != 2'd3) |=> ledPullLow[0]);

  // R9: without a tick or an input change the output holds
  p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !slotTick && cellStatus == $past(cellStatus) &&
     dispMode == $past(dispMode)) |=> $stable(ledPullLow));

  // R10: series operation keeps the other indicators released
  for (genvar i = 1; i < NUM_LEDS; i++) begin : g_series
    p_series_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
      seriesMode |-> !ledPullLow[i]);
  end

  // R11: outputs released while reset is held
  always_ff @(posedge clk) begin
    if (!rstN && $past(!rstN))
      p_reset_released_r11: assert (ledPullLow == '0);
  end

endmodule

bind led_status_pattern ledpat_checker #(.NUM_LEDS(NUM_LEDS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .slotTick  (slotTick),
  .seriesMode(seriesMode),
  .dispMode  (dispMode),
  .cellStatus(cellStatus),
  .ledPullLow(ledPullLow)
);

// File: tb/sim_led_status_pattern.sv
`timescale 1ns/1ps
module sim_led_status_pattern;

  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         slotTick = 1'b0;
  logic         seriesMode = 1'b0;
  logic [1:0]   dispMode = 2'd0;
  logic [2*N-1:0] cellStatus = '0;
  logic [N-1:0] ledPullLow;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  led_status_pattern #(.NUM_LEDS(N)) u0 (
    .clk(clk), .rstN(rstN), .slotTick(slotTick), .seriesMode(seriesMode),
    .dispMode(dispMode), .cellStatus(cellStatus), .ledPullLow(ledPullLow)
  );

  // expected level from slot index k since restart
  function automatic bit expLow(int m, int st, int k);
    int mm;
    int p;
    mm = (m == 3) ? 1 : m;
    p  = k % 6;
    case (st)
      0: return 1'b0;
      1: return (mm == 2) ? (p < 5) : 1'b1;
      2: return (mm == 0) ? (p < 5) : (mm == 1 ? 1'b0 : 1'b1);
      default: return (mm == 0) ? (p < 3) : (p % 2 == 0);
    endcase
  endfunction

  function automatic string tagFor(int m, int st);
    if (st == 0) return "R1";
    if (m == 3) return "R7";
    if (m == 1) return "R5";
    if (m == 2) return "R6";
    if (st == 1) return "R2";
    if (st == 2) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, int ch, bit act, bit exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s ch%0d t=%0t actual=%0b expected=%0b", tag, ch, $time, act, exp);
    end
  endtask

  task automatic tickSlot();
    slotTick = 1'b1;
    @(negedge clk);
    slotTick = 1'b0;
  endtask

  // apply new inputs (optionally with a coincident tick) and walk 12 slots
  task automatic walk(int m, int s0, int s1, bit tickAtChange, string extraTag);
    dispMode   = 2'(m);
    cellStatus = {2'(s1), 2'(s0)};
    slotTick   = tickAtChange;
    @(negedge clk);
    slotTick = 1'b0;
    for (int k = 0; k < 12; k++) begin
      check(tagFor(m, s0), 0, ledPullLow[0], expLow(m, s0, k));
      check(extraTag, 0, ledPullLow[0], expLow(m, s0, k));
      check(tagFor(m, s1), 1, ledPullLow[1], seriesMode ? 1'b0 : expLow(m, s1, k));
      if (k == 2) begin
        repeat (3) @(negedge clk);
        check("R9", 0, ledPullLow[0], expLow(m, s0, k));
        check("R9", 1, ledPullLow[1], seriesMode ? 1'b0 : expLow(m, s1, k));
      end
      tickSlot();
    end
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog expired t=%0t actual=running expected=finished", $time);
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    cellStatus = {2'd3, 2'd1};
    dispMode   = 2'd0;
    repeat (4) @(negedge clk);
    check("R11", 0, ledPullLow[0], 1'b0);
    check("R11", 1, ledPullLow[1], 1'b0);
    cellStatus = '0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 0, ledPullLow[0], 1'b0);

    // full sweep, parallel: channel 1 gets a different status
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        walk(m, s, (s + 2) % 4, 1'b0, "R10");
      end
    end

    // R8: restart must win over a tick in the same cycle
    walk(0, 0, 0, 1'b0, "R8");
    walk(0, 2, 1, 1'b1, "R8");
    walk(2, 1, 2, 1'b1, "R8");

    // R8: mode-only change restarts the phase
    dispMode   = 2'd1;
    cellStatus = {2'd3, 2'd3};
    @(negedge clk);
    tickSlot();
    check("R8", 0, ledPullLow[0], 1'b0);
    walk(2, 3, 3, 1'b0, "R8");

    // R10: series operation silences channel 1
    seriesMode = 1'b1;
    walk(0, 2, 1, 1'b0, "R10");
    walk(2, 3, 2, 1'b0, "R10");
    seriesMode = 1'b0;
    walk(0, 1, 3, 1'b0, "R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule